// File: doc/BRIEF.md
# Auto-Selecting Host Register Bus Port

This block is a slave port that gives an 8-bit host processor read and write access to a small internal register file. The host can use one of three bus styles. The first is a Motorola-style bus with a separate address bus, a read/not-write direction line and a data strobe. The second is an Intel-style bus with a separate address bus and separate write and read strobes. The third is an Intel-style bus where the address and data share the AD lines and an address latch enable (ALE) pulse marks the address phase. The block does not need a configuration register to pick the style. It looks at the ALE pin.

If ALE is held high, the port uses Motorola signalling. If ALE is held low, it uses separate-address Intel signalling. The first edge seen on ALE locks the port into multiplexed mode, and only a hardware reset releases that lock. Every host input passes through a two-stage synchroniser, or a matching two-stage delay for the address and data lines, into the port clock domain. This keeps strobes, address and data aligned with each other. The data bus is modelled as separate `ad_in` and `ad_out` buses plus an output enable, so the pad ring forms the tri-state buffer. The enable is high only while a qualified read is in progress.

The host bus has no flow control. Every access completes within a fixed number of port clocks, so there is no valid/ready handshake. The host must keep each strobe asserted, and the address and data stable, for at least 4 port clocks. It must also keep chip select and data stable for 4 port clocks after it releases a strobe.

Top module: `host_bus_port`

## Requirements
- R1: While reset is held and right after it, `ad_oe` is 0 and `ad_out` is 00h. Every register in the stub reads 00h, except the status register, which reads 52h (transmit side may be written, receive line idle).
- R2: If ALE is high when reset is released and stays high, `bus_mode` is 2'b00. In this mode, `rdn_dsn` low is the data strobe, and `wrn_rnw` high means read while `wrn_rnw` low means write.
- R3: If ALE is low when reset is released and stays low, `bus_mode` is 2'b01. In this mode, `wrn_rnw` low is the write strobe and `rdn_dsn` low is the read strobe.
- R4: After the port has settled, any rising or falling ALE edge sets `bus_mode` to 2'b10 within 4 clocks. In this mode, the register address is the value of `ad_in[6:0]` seen while ALE was last high.
- R5: Multiplexed mode stays in force whatever ALE does afterwards. A hardware reset brings back level-based selection.
- R6: In the two separate-address modes, the register address comes from `addr[6:0]`. In multiplexed mode, `addr` is ignored.
- R7: A write changes the addressed register exactly once per access, when the write strobe is released. The value written is the `ad_in` value present while the strobe was asserted.
- R8: `ad_oe` rises within 4 clocks after a qualified read strobe asserts and falls within 4 clocks after it is released. While `ad_oe` is high, `ad_out` holds the contents of the addressed register.
- R9: While `cs_n` is high, strobes are ignored. No register changes and `ad_oe` stays 0.
- R10: The status register at address 05h ignores writes. Addresses 10h and above read 00h and ignore writes. Addresses 00h–0Fh, other than 05h, read back what was last written to them.
- R11: The ALE level seen during the first 3 clocks after reset never counts as an edge. Tying ALE high through reset therefore does not lock multiplexed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ale | input | 1 | Address latch enable; its level or its edges select the bus style |
| cs_n | input | 1 | Chip select, active low |
| wrn_rnw | input | 1 | Write strobe (Intel styles) or read/not-write direction (Motorola style) |
| rdn_dsn | input | 1 | Read strobe (Intel styles) or data strobe (Motorola style), active low |
| addr | input | 7 | Separate register address |
| ad_in | input | 8 | Data lines in (also carry the address in multiplexed mode) |
| ad_out | output | 8 | Read data out |
| ad_oe | output | 1 | Output enable for the data lines |
| bus_mode | output | 2 | Current style: 00 Motorola, 01 Intel separate, 10 Intel multiplexed |

## Verification
Each of the three bus styles is used for a run of random writes and reads over addresses 00h–17h, checked against a model of the register file. These runs confirm that each style decodes its own strobes correctly. The address range mixes writable registers, the read-only status register and out-of-range addresses. In multiplexed mode, the `addr` pins carry random values, so a port that took its address from the wrong lines would return wrong data. Directed cases cover the remaining behaviour:
- reset with ALE tied high, which must not lock;
- a single ALE toggle;
- ALE held high after the lock;
- strobes with `cs_n` high;
- a reset that releases the lock.

Together these separate a level decision from an edge decision, and a sticky lock from a lock that drops.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef enum logic [1:0] {
    BM_MOTO  = 2'b00,
    BM_INTEL = 2'b01,
    BM_MUX   = 2'b10
  } bus_mode_e;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int          W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {W{RST_VAL}};
      q      <= {W{RST_VAL}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hbp_mode_ctl.sv
module hbp_mode_ctl
  import hbp_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ale_s,
  output bus_mode_e mode,
  output logic      settled
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic [CNT_W-1:0] settle_cnt;
  logic             ale_prev;
  logic             locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      ale_prev   <= 1'b0;
      locked     <= 1'b0;
    end else begin
      ale_prev <= ale_s;
      if (!settled) settle_cnt <= settle_cnt + 1'b1;
      if (settled && (ale_s != ale_prev)) locked <= 1'b1;
    end
  end

  assign settled = (settle_cnt == CNT_W'(SETTLE_CYCLES));

  always_comb begin
    if (locked)     mode = BM_MUX;
    else if (ale_s) mode = BM_MOTO;
    else            mode = BM_INTEL;
  end

  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  a_r4_lock_gives_mux: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (mode == BM_MUX));

  a_r11_no_early_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> !locked);
endmodule

// File: rtl/hbp_access.sv
module hbp_access
  import hbp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_mode_e         mode,
  input  logic              settled,
  input  logic              cs_n_s,
  input  logic              wrn_rnw_s,
  input  logic              rdn_dsn_s,
  input  logic              ale_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] ad_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe
);
  logic              sel;
  logic              rd_act;
  logic              wr_act;
  logic              wr_act_q;
  logic [ADDR_W-1:0] mux_addr;
  logic [ADDR_W-1:0] cur_addr;

  always_comb begin
    sel = settled && !cs_n_s;
    if (mode == BM_MOTO) begin
      rd_act = sel && !rdn_dsn_s &&  wrn_rnw_s;
      wr_act = sel && !rdn_dsn_s && !wrn_rnw_s;
    end else begin
      wr_act = sel && !wrn_rnw_s;
      rd_act = sel && !rdn_dsn_s && wrn_rnw_s;
    end
    cur_addr = (mode == BM_MUX) ? mux_addr : addr_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_addr <= '0;
      wr_act_q <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
    end else begin
      if (ale_s) mux_addr <= ad_s[ADDR_W-1:0];
      wr_act_q <= wr_act;
      if (wr_act) begin
        wr_addr <= cur_addr;
        wr_data <= ad_s;
      end
      ad_oe  <= rd_act;
      ad_out <= rd_act ? rd_data : '0;
    end
  end

  assign rd_addr = cur_addr;
  assign wr_en   = wr_act_q && !wr_act;

  a_r7_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r9_cs_gates_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_s) |-> !ad_oe);

  a_r8_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && rdn_dsn_s) |=> !ad_oe);
endmodule

// File: rtl/hbp_regfile.sv
module hbp_regfile #(
  parameter int          ADDR_W      = 7,
  parameter int          DATA_W      = 8,
  parameter int          REG_COUNT   = 16,
  parameter int          STATUS_ADDR = 5,
  parameter logic [7:0]  STATUS_VAL  = 8'h52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [DATA_W-1:0] word [REG_COUNT];
  logic              wr_hit;

  assign wr_hit = wr_en && (int'(wr_addr) < REG_COUNT) && (int'(wr_addr) != STATUS_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) word[i] <= '0;
    end else if (wr_hit) begin
      word[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) == STATUS_ADDR)   rd_data = DATA_W'(STATUS_VAL);
    else if (int'(rd_addr) < REG_COUNT) rd_data = word[rd_addr[IDX_W-1:0]];
  end
endmodule

// File: rtl/host_bus_port.sv
module host_bus_port
  import hbp_pkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter int         DATA_W      = 8,
  parameter int         REG_COUNT   = 16,
  parameter int         STATUS_ADDR = 5,
  parameter logic [7:0] STATUS_VAL  = 8'h52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              wrn_rnw,
  input  logic              rdn_dsn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [1:0]        bus_mode
);
  localparam int PATH_W = ADDR_W + DATA_W;

  logic [2:0]        ctl_s;
  logic              ale_s;
  logic [PATH_W-1:0] path_s;
  bus_mode_e         mode;
  logic              settled;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  hbp_sync #(.W(3), .RST_VAL(1'b1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, wrn_rnw, rdn_dsn}), .q(ctl_s));

  hbp_sync #(.W(1), .RST_VAL(1'b0)) u_ale_sync (
    .clk(clk), .rst_n(rst_n), .d(ale), .q(ale_s));

  hbp_sync #(.W(PATH_W), .RST_VAL(1'b0)) u_path_dly (
    .clk(clk), .rst_n(rst_n), .d({addr, ad_in}), .q(path_s));

  hbp_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .mode(mode), .settled(settled));

  hbp_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_access (
    .clk(clk), .rst_n(rst_n), .mode(mode), .settled(settled),
    .cs_n_s(ctl_s[2]), .wrn_rnw_s(ctl_s[1]), .rdn_dsn_s(ctl_s[0]),
    .ale_s(ale_s), .addr_s(path_s[PATH_W-1:DATA_W]), .ad_s(path_s[DATA_W-1:0]),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ad_out(ad_out), .ad_oe(ad_oe));

  hbp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT),
                .STATUS_ADDR(STATUS_ADDR), .STATUS_VAL(STATUS_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  assign bus_mode = mode;

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!ad_oe || !rst_n));
endmodule

// File: tb/host_bus_port_tb_top.sv
`timescale 1ns/1ps
module host_bus_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic       cs_n = 1'b1;
  logic       wrn_rnw = 1'b1;
  logic       rdn_dsn = 1'b1;
  logic [6:0] addr = '0;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic [1:0] bus_mode;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int          style = 0;
  logic [7:0]  model [128];

  always #2 clk = ~clk;

  host_bus_port dut_i (.clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n),
    .wrn_rnw(wrn_rnw), .rdn_dsn(rdn_dsn), .addr(addr), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .bus_mode(bus_mode));

  function automatic logic [7:0] exp_read(logic [6:0] a);
    if (a == 7'h05) return 8'h52;
    if (a >= 7'h10) return 8'h00;
    return model[a];
  endfunction

  function automatic bit writable(logic [6:0] a);
    return (a < 7'h10) && (a != 7'h05);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic lvl);
    @(negedge clk);
    rst_n = 1'b0; ale = lvl; cs_n = 1'b1; wrn_rnw = 1'b1; rdn_dsn = 1'b1;
    idle(3);
    check8("R1 oe in reset", {7'd0, ad_oe}, 8'h00);
    check8("R1 out in reset", ad_out, 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    idle(8);
  endtask

  task automatic addr_phase(logic [6:0] a);
    if (style == 2) begin
      addr  = 7'($urandom);
      ad_in = {1'($urandom), a};
      ale = 1'b1; idle(3);
      ale = 1'b0; idle(3);
    end else begin
      addr = a;
    end
  endtask

  task automatic wr_cycle(logic [6:0] a, logic [7:0] d);
    addr_phase(a);
    ad_in = d;
    if (style == 0) begin
      wrn_rnw = 1'b0; cs_n = 1'b0; idle(1);
      rdn_dsn = 1'b0; idle(4); rdn_dsn = 1'b1; idle(4);
    end else begin
      cs_n = 1'b0; idle(1);
      wrn_rnw = 1'b0; idle(4); wrn_rnw = 1'b1; idle(4);
    end
    cs_n = 1'b1; wrn_rnw = 1'b1; idle(2);
    if (writable(a)) model[a] = d;
  endtask

  task automatic rd_cycle(logic [6:0] a, string tag);
    addr_phase(a);
    ad_in = 8'($urandom);
    wrn_rnw = 1'b1; cs_n = 1'b0; idle(1);
    rdn_dsn = 1'b0; idle(5);
    check8({tag, " R8 oe during read"}, {7'd0, ad_oe}, 8'h01);
    check8(tag, ad_out, exp_read(a));
    rdn_dsn = 1'b1; idle(5);
    check8("R8 oe after read", {7'd0, ad_oe}, 8'h00);
    cs_n = 1'b1; idle(2);
  endtask

  task automatic random_ops(int n, string tag);
    for (int k = 0; k < n; k++) begin
      logic [6:0] a;
      a = 7'($urandom % 24);
      if ($urandom % 2 == 0) wr_cycle(a, 8'($urandom));
      else rd_cycle(a, tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    // Motorola style, ALE tied high through reset (R2, R11)
    style = 0;
    do_reset(1'b1);
    check8("R2 R11 mode with ALE high", {6'd0, bus_mode}, 8'h00);
    for (int i = 0; i < 16; i++) rd_cycle(7'(i), "R1 reset value");
    wr_cycle(7'h03, 8'hA5);
    rd_cycle(7'h03, "R7 R2 write then read");
    wr_cycle(7'h05, 8'hFF);
    rd_cycle(7'h05, "R10 status read-only");
    wr_cycle(7'h64, 8'h3C);
    rd_cycle(7'h64, "R10 out of range");
    random_ops(40, "R2 R6 moto random");
    check8("R2 mode kept", {6'd0, bus_mode}, 8'h00);

    // Intel separate style (R3)
    style = 1;
    do_reset(1'b0);
    check8("R3 mode with ALE low", {6'd0, bus_mode}, 8'h00 | 8'h01);
    wr_cycle(7'h0F, 8'h5A);
    rd_cycle(7'h0F, "R3 R7 intel write then read");
    random_ops(40, "R3 R6 intel random");
    // chip select inactive: strobes ignored (R9)
    addr = 7'h02; ad_in = 8'hEE; cs_n = 1'b1;
    wrn_rnw = 1'b0; idle(4); wrn_rnw = 1'b1; idle(4);
    rdn_dsn = 1'b0; idle(5);
    check8("R9 oe with cs high", {7'd0, ad_oe}, 8'h00);
    rdn_dsn = 1'b1; idle(4);
    rd_cycle(7'h02, "R9 no write with cs high");

    // Lock into multiplexed mode (R4, R5, R6)
    style = 2;
    ale = 1'b1; idle(4);
    check8("R4 mode after ALE edge", {6'd0, bus_mode}, 8'h02);
    ale = 1'b0; idle(4);
    wr_cycle(7'h07, 8'hC3);
    rd_cycle(7'h07, "R4 R6 mux write then read");
    random_ops(40, "R4 R6 mux random");
    ale = 1'b1; idle(12);
    check8("R5 lock with ALE high", {6'd0, bus_mode}, 8'h02);
    ale = 1'b0; idle(12);
    check8("R5 lock with ALE low", {6'd0, bus_mode}, 8'h02);

    // Reset releases the lock (R5, R1)
    style = 0;
    do_reset(1'b1);
    check8("R5 mode after reset", {6'd0, bus_mode}, 8'h00);
    rd_cycle(7'h07, "R1 cleared by reset");
    rd_cycle(7'h05, "R1 status after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule